// File: doc/BRIEF.md
# Read-Out Protection Level Controller

This block turns a 32-bit protection word, fetched from non-volatile configuration while reset is held, into one of four protection levels. From that level it drives the access-control outputs of the device: whether the debug port is enabled, whether the debug configuration is locked, and the command class granted to the debug mailbox and to the in-system programming (ISP) command path. The level is fixed at reset. Nothing that happens afterwards changes these outputs until the next reset.

While running, the block handles three kinds of request that change the stored protection word. These are a level write with a target level, an erase-all from the ISP path, and an erase-all from the debug mailbox. It serves at most one request per cycle and applies the transition rules. An accepted request produces an acknowledge pulse together with a write-back of the new word, which takes effect only after the next reset. A rejected request produces an error pulse and leaves the stored word unchanged.

Top module: `rop_level_ctrl`

## Requirements
- R1: With cfg_word = 0xFFFFFFFF at reset, the outputs settle to prot_level 0, dbg_en 1, dbg_cfg_lock 0, mbx_class 0 (full) and isp_class 0 (full).
- R2: With cfg_word = 0x00000003 at reset, the outputs settle to prot_level 1, dbg_en 0, dbg_cfg_lock 0, mbx_class 1 (limited) and isp_class 1 (limited).
- R3: With cfg_word = 0x00000001 at reset, the outputs settle to prot_level 2, dbg_en 0, dbg_cfg_lock 1, mbx_class 1 (limited) and isp_class 2 (minimal).
- R4: With cfg_word = 0x00000000, or with any word other than the three above, the outputs settle to prot_level 3, dbg_en 0, dbg_cfg_lock 1, mbx_class 3 (none) and isp_class 3 (none).
- R5: prot_level, dbg_en, dbg_cfg_lock, mbx_class and isp_class change only while rst is high. Accepted requests do not alter them.
- R6: A level write is accepted when the stored level is 0 and wr_level is 1, 2 or 3. One cycle after the request, req_ack and wb_valid pulse for one cycle, and wb_word carries the target's encoding (level 1 = 0x3, level 2 = 0x1, level 3 = 0x0).
- R7: A level write is rejected when the stored level is not 0 or when wr_level is 0. One cycle later req_err pulses for one cycle, and wb_valid and req_ack stay low.
- R8: An erase-all from either path is accepted when the stored level is 0, 1 or 2. The write-back carries 0xFFFFFFFF, and the stored level becomes 0.
- R9: At stored level 3, including a level that was decoded from an unrecognised word, every request is rejected with req_err.
- R10: When several requests arrive in one cycle, only one is served: an ISP erase first, then a mailbox erase, then a level write. The requests that lose produce no pulse and have no effect.
- R11: Each request is judged against the stored level left by the last accepted request since reset, not against the reset-time level.
- R12: req_ack and req_err never pulse together. wb_valid pulses exactly when req_ack does. In a cycle after no request, neither req_ack nor req_err pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; cfg_word is decoded while it is high |
| cfg_word | input | 32 | Protection word from non-volatile configuration |
| wr_req | input | 1 | Level write request strobe |
| wr_level | input | 2 | Target level of a level write |
| isp_erase_req | input | 1 | Erase-all request from the ISP path |
| mbx_erase_req | input | 1 | Erase-all request from the debug mailbox |
| prot_level | output | 2 | Protection level in effect |
| dbg_en | output | 1 | Debug port enable |
| dbg_cfg_lock | output | 1 | Debug configuration lock |
| mbx_class | output | 2 | Debug-mailbox command class (0 full, 1 limited, 3 none) |
| isp_class | output | 2 | ISP command class (0 full, 1 limited, 2 minimal, 3 none) |
| req_ack | output | 1 | Request accepted pulse |
| req_err | output | 1 | Request rejected pulse |
| wb_valid | output | 1 | Write-back strobe for the new protection word |
| wb_word | output | 32 | New protection word to store |

## Verification
An erase-all and a level write can land in the same cycle. So can erases from both paths. The bench raises these strobes together at level 0 and at level 2. It expects exactly one acknowledge, carrying the erased word, from the higher-priority path. It then proves that the losing write was discarded: a follow-up write must still be judged against level 0.

// File: rtl/rop_pkg.sv
package rop_pkg;

    localparam int WORD_W = 32;
    localparam int LVL_W  = 2;
    localparam int NREQ   = 3;

    localparam logic [WORD_W-1:0] WORD_OPEN    = 32'hFFFF_FFFF;
    localparam logic [WORD_W-1:0] WORD_DBG_OFF = 32'h0000_0003;
    localparam logic [WORD_W-1:0] WORD_DBG_LCK = 32'h0000_0001;
    localparam logic [WORD_W-1:0] WORD_SEALED  = 32'h0000_0000;

    // request slots, index is priority (0 highest)
    localparam int SLOT_ISP = 0;
    localparam int SLOT_MBX = 1;
    localparam int SLOT_WR  = 2;

    typedef enum logic [LVL_W-1:0] {
        LVL_OPEN    = 2'd0,
        LVL_DBG_OFF = 2'd1,
        LVL_DBG_LCK = 2'd2,
        LVL_SEALED  = 2'd3
    } lvl_e;

    typedef enum logic [1:0] {
        CLS_FULL    = 2'd0,
        CLS_LIMITED = 2'd1,
        CLS_MINIMAL = 2'd2,
        CLS_NONE    = 2'd3
    } cls_e;

    typedef struct packed {
        logic dbg_en;
        logic dbg_lock;
        cls_e mbx;
        cls_e isp;
    } access_t;

    typedef struct packed {
        logic              ack;
        logic              err;
        logic              wb;
        logic [WORD_W-1:0] word;
    } resp_t;

    function automatic lvl_e word_to_level(input logic [WORD_W-1:0] w);
        lvl_e l;
        unique case (w)
            WORD_OPEN:    l = LVL_OPEN;
            WORD_DBG_OFF: l = LVL_DBG_OFF;
            WORD_DBG_LCK: l = LVL_DBG_LCK;
            default:      l = LVL_SEALED;
        endcase
        return l;
    endfunction

    function automatic logic [WORD_W-1:0] level_to_word(input lvl_e l);
        logic [WORD_W-1:0] w;
        unique case (l)
            LVL_OPEN:    w = WORD_OPEN;
            LVL_DBG_OFF: w = WORD_DBG_OFF;
            LVL_DBG_LCK: w = WORD_DBG_LCK;
            default:     w = WORD_SEALED;
        endcase
        return w;
    endfunction

    function automatic access_t level_access(input lvl_e l);
        access_t a;
        unique case (l)
            LVL_OPEN:    a = '{dbg_en: 1'b1, dbg_lock: 1'b0, mbx: CLS_FULL,    isp: CLS_FULL};
            LVL_DBG_OFF: a = '{dbg_en: 1'b0, dbg_lock: 1'b0, mbx: CLS_LIMITED, isp: CLS_LIMITED};
            LVL_DBG_LCK: a = '{dbg_en: 1'b0, dbg_lock: 1'b1, mbx: CLS_LIMITED, isp: CLS_MINIMAL};
            default:     a = '{dbg_en: 1'b0, dbg_lock: 1'b1, mbx: CLS_NONE,    isp: CLS_NONE};
        endcase
        return a;
    endfunction

endpackage

// File: rtl/rop_decode.sv
module rop_decode
    import rop_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output lvl_e              level,
    output access_t           acc
);
    always_comb begin
        level = word_to_level(word);
        acc   = level_access(level);
    end
endmodule

// File: rtl/rop_arbiter.sv
module rop_arbiter #(
    parameter int N = 3
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] gnt
);
    for (genvar i = 0; i < N; i++) begin : g_slot
        if (i == 0) begin : g_top
            assign gnt[i] = req[i];
        end else begin : g_low
            assign gnt[i] = req[i] & ~(|req[i-1:0]);
        end
    end
endmodule

// File: rtl/rop_transition.sv
module rop_transition
    import rop_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  lvl_e            init_level,
    input  logic [NREQ-1:0] gnt,
    input  lvl_e            wr_target,
    output resp_t           resp
);
    lvl_e              stored_q;
    lvl_e              next_lvl;
    logic              any_gnt;
    logic              legal;
    logic [WORD_W-1:0] next_word;

    always_comb begin
        any_gnt   = |gnt;
        legal     = 1'b0;
        next_lvl  = stored_q;
        next_word = level_to_word(stored_q);
        if (gnt[SLOT_ISP] || gnt[SLOT_MBX]) begin
            legal     = (stored_q != LVL_SEALED);
            next_lvl  = LVL_OPEN;
            next_word = WORD_OPEN;
        end else if (gnt[SLOT_WR]) begin
            legal     = (stored_q == LVL_OPEN) && (wr_target != LVL_OPEN);
            next_lvl  = wr_target;
            next_word = level_to_word(wr_target);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stored_q <= init_level;
            resp     <= '0;
        end else begin
            resp.ack <= any_gnt & legal;
            resp.err <= any_gnt & ~legal;
            resp.wb  <= any_gnt & legal;
            if (any_gnt && legal) begin
                resp.word <= next_word;
                stored_q  <= next_lvl;
            end
        end
    end
endmodule

// File: rtl/rop_level_ctrl.sv
module rop_level_ctrl
    import rop_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [31:0] cfg_word,
    input  logic        wr_req,
    input  logic [1:0]  wr_level,
    input  logic        isp_erase_req,
    input  logic        mbx_erase_req,
    output logic [1:0]  prot_level,
    output logic        dbg_en,
    output logic        dbg_cfg_lock,
    output logic [1:0]  mbx_class,
    output logic [1:0]  isp_class,
    output logic        req_ack,
    output logic        req_err,
    output logic        wb_valid,
    output logic [31:0] wb_word
);
    lvl_e            dec_level;
    access_t         dec_acc;
    lvl_e            lvl_q;
    access_t         acc_q;
    logic [NREQ-1:0] req_vec;
    logic [NREQ-1:0] gnt_vec;
    resp_t           resp;

    rop_decode u_decode (
        .word  (cfg_word),
        .level (dec_level),
        .acc   (dec_acc)
    );

    // level and access rights are latched only while reset is held
    always_ff @(posedge clk) begin
        if (rst) begin
            lvl_q <= dec_level;
            acc_q <= dec_acc;
        end
    end

    always_comb begin
        req_vec           = '0;
        req_vec[SLOT_ISP] = isp_erase_req;
        req_vec[SLOT_MBX] = mbx_erase_req;
        req_vec[SLOT_WR]  = wr_req;
    end

    rop_arbiter #(.N(NREQ)) u_arb (
        .req (req_vec),
        .gnt (gnt_vec)
    );

    rop_transition u_trans (
        .clk        (clk),
        .rst        (rst),
        .init_level (dec_level),
        .gnt        (gnt_vec),
        .wr_target  (lvl_e'(wr_level)),
        .resp       (resp)
    );

    assign prot_level   = lvl_q;
    assign dbg_en       = acc_q.dbg_en;
    assign dbg_cfg_lock = acc_q.dbg_lock;
    assign mbx_class    = acc_q.mbx;
    assign isp_class    = acc_q.isp;
    assign req_ack      = resp.ack;
    assign req_err      = resp.err;
    assign wb_valid     = resp.wb;
    assign wb_word      = resp.word;
endmodule

// File: rtl/rop_level_ctrl_chk.sv
module rop_level_ctrl_chk (
    input logic        clk,
    input logic        rst,
    input logic [31:0] cfg_word,
    input logic        wr_req,
    input logic [1:0]  wr_level,
    input logic        isp_erase_req,
    input logic        mbx_erase_req,
    input logic [1:0]  prot_level,
    input logic        dbg_en,
    input logic        dbg_cfg_lock,
    input logic [1:0]  mbx_class,
    input logic [1:0]  isp_class,
    input logic        req_ack,
    input logic        req_err,
    input logic        wb_valid,
    input logic [31:0] wb_word
);
    a_r12_ack_err_excl: assert property (@(posedge clk) disable iff (rst)
        !(req_ack && req_err));

    a_r12_wb_with_ack: assert property (@(posedge clk) disable iff (rst)
        wb_valid == req_ack);

    a_r12_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !(wr_req || isp_erase_req || mbx_erase_req) |=> !req_ack && !req_err);

    a_r5_level_stable: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> $stable(prot_level) && $stable(dbg_en) && $stable(dbg_cfg_lock)
                 && $stable(mbx_class) && $stable(isp_class));

    a_r4_sealed_locks: assert property (@(posedge clk) disable iff (rst)
        prot_level == 2'd3 |-> !dbg_en && dbg_cfg_lock && mbx_class == 2'd3 && isp_class == 2'd3);

    a_r1_dbg_only_open: assert property (@(posedge clk) disable iff (rst)
        dbg_en |-> prot_level == 2'd0 && isp_class == 2'd0);

    a_r2_limited_mbx: assert property (@(posedge clk) disable iff (rst)
        mbx_class == 2'd1 |-> (prot_level == 2'd1 || prot_level == 2'd2));

    a_r10_isp_erase_served: assert property (@(posedge clk) disable iff (rst)
        isp_erase_req |=> (req_ack || req_err) && (!req_ack || wb_word == 32'hFFFF_FFFF));

    a_r7_write_open_rejected: assert property (@(posedge clk) disable iff (rst)
        wr_req && !isp_erase_req && !mbx_erase_req && wr_level == 2'd0 |=> req_err);
endmodule

bind rop_level_ctrl rop_level_ctrl_chk u_chk (.*);

// File: tb/tb_rop_level_ctrl.sv
module tb_rop_level_ctrl;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] cfg_word = 32'hFFFF_FFFF;
    logic        wr_req = 1'b0;
    logic [1:0]  wr_level = 2'd0;
    logic        isp_erase_req = 1'b0;
    logic        mbx_erase_req = 1'b0;
    logic [1:0]  prot_level;
    logic        dbg_en;
    logic        dbg_cfg_lock;
    logic [1:0]  mbx_class;
    logic [1:0]  isp_class;
    logic        req_ack;
    logic        req_err;
    logic        wb_valid;
    logic [31:0] wb_word;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    typedef struct {
        logic        ack;
        logic [31:0] word;
        string       tag;
    } exp_t;

    exp_t sb_q[$];

    always #5 clk = ~clk;

    rop_level_ctrl dut (.*);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // expected access outputs, packed {level, dbg_en, lock, mbx, isp}
    function automatic logic [7:0] ref_access(input logic [31:0] w);
        case (w)
            32'hFFFF_FFFF: return {2'd0, 1'b1, 1'b0, 2'd0, 2'd0};
            32'h0000_0003: return {2'd1, 1'b0, 1'b0, 2'd1, 2'd1};
            32'h0000_0001: return {2'd2, 1'b0, 1'b1, 2'd1, 2'd2};
            default:       return {2'd3, 1'b0, 1'b1, 2'd3, 2'd3};
        endcase
    endfunction

    function automatic logic [7:0] act_access();
        return {prot_level, dbg_en, dbg_cfg_lock, mbx_class, isp_class};
    endfunction

    task automatic do_reset(input logic [31:0] w, input string tag);
        @(negedge clk);
        rst      = 1'b1;
        cfg_word = w;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        chk({tag, " reset access"}, {24'd0, act_access()}, {24'd0, ref_access(w)});
        chk({tag, " reset pulses"}, {29'd0, req_ack, req_err, wb_valid}, 32'd0);
        cfg_word = 32'hDEAD_BEEF; // must not matter after reset
    endtask

    // one request cycle; every request cycle yields exactly one ack or err
    task automatic issue(input logic w, input logic [1:0] lvl, input logic ie, input logic me,
                         input logic exp_ack, input logic [31:0] exp_word, input string tag);
        exp_t e;
        @(negedge clk);
        wr_req        = w;
        wr_level      = lvl;
        isp_erase_req = ie;
        mbx_erase_req = me;
        e.ack  = exp_ack;
        e.word = exp_word;
        e.tag  = tag;
        sb_q.push_back(e);
        @(negedge clk);
        wr_req        = 1'b0;
        isp_erase_req = 1'b0;
        mbx_erase_req = 1'b0;
    endtask

    // monitor: pop and compare whenever a response pulse appears
    always @(negedge clk) begin
        if (!rst && (req_ack || req_err || wb_valid)) begin
            if (sb_q.size() == 0) begin
                checks++;
                errors++;
                $display("FAIL R12 unexpected pulse actual=%b%b%b expected=000", req_ack, req_err, wb_valid);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                chk({e.tag, " ack"}, {31'd0, req_ack}, {31'd0, e.ack});
                chk({e.tag, " err R12"}, {31'd0, req_err}, {31'd0, ~e.ack});
                chk({e.tag, " wb_valid R12"}, {31'd0, wb_valid}, {31'd0, e.ack});
                if (e.ack) chk({e.tag, " wb_word"}, wb_word, e.word);
            end
        end
    end

    task automatic drain(input string tag);
        repeat (2) @(negedge clk);
        chk({tag, " all responses seen"}, sb_q.size(), 32'd0);
        sb_q.delete();
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] snap;
        // R1 open level, then transitions judged against stored level (R11)
        do_reset(32'hFFFF_FFFF, "R1");
        snap = act_access();
        issue(1'b1, 2'd2, 1'b0, 1'b0, 1'b1, 32'h0000_0001, "R6 write L2 from L0");
        issue(1'b1, 2'd3, 1'b0, 1'b0, 1'b0, 32'h0,        "R11 write L3 after stored L2");
        chk("R5 level unchanged after accepted write", {24'd0, act_access()}, {24'd0, snap});
        issue(1'b0, 2'd0, 1'b1, 1'b0, 1'b1, 32'hFFFF_FFFF, "R8 isp erase from stored L2");
        issue(1'b1, 2'd0, 1'b0, 1'b0, 1'b0, 32'h0,        "R7 write target L0");
        issue(1'b1, 2'd3, 1'b0, 1'b0, 1'b1, 32'h0000_0000, "R6 write L3 from L0");
        issue(1'b0, 2'd0, 1'b0, 1'b1, 1'b0, 32'h0,        "R11 mbx erase after stored L3");
        issue(1'b0, 2'd0, 1'b1, 1'b0, 1'b0, 32'h0,        "R9 isp erase after stored L3");
        drain("R1 block");
        chk("R5 level unchanged after block", {24'd0, act_access()}, {24'd0, snap});

        // R2 level 1
        do_reset(32'h0000_0003, "R2");
        issue(1'b1, 2'd2, 1'b0, 1'b0, 1'b0, 32'h0,        "R7 write from L1");
        issue(1'b0, 2'd0, 1'b0, 1'b1, 1'b1, 32'hFFFF_FFFF, "R8 mbx erase from L1");
        issue(1'b1, 2'd1, 1'b0, 1'b0, 1'b1, 32'h0000_0003, "R11 write L1 after erase");
        drain("R2 block");
        chk("R5 L1 outputs held", {24'd0, act_access()}, {24'd0, ref_access(32'h3)});

        // R3 level 2 and same-cycle arbitration R10
        do_reset(32'h0000_0001, "R3");
        issue(1'b1, 2'd3, 1'b0, 1'b0, 1'b0, 32'h0,        "R7 write from L2");
        issue(1'b1, 2'd3, 1'b1, 1'b0, 1'b1, 32'hFFFF_FFFF, "R10 isp erase beats write");
        issue(1'b1, 2'd2, 1'b0, 1'b1, 1'b1, 32'hFFFF_FFFF, "R10 mbx erase beats write");
        issue(1'b1, 2'd2, 1'b0, 1'b0, 1'b1, 32'h0000_0001, "R10 losing write discarded");
        drain("R3 block");

        // R10 all three together at level 0
        do_reset(32'hFFFF_FFFF, "R1 again");
        issue(1'b1, 2'd3, 1'b1, 1'b1, 1'b1, 32'hFFFF_FFFF, "R10 three-way isp wins");
        issue(1'b1, 2'd1, 1'b0, 1'b0, 1'b1, 32'h0000_0003, "R10 stored still L0");
        drain("R10 block");

        // R4 sealed and unknown words, R9
        do_reset(32'h0000_0000, "R4 zero");
        issue(1'b0, 2'd0, 1'b1, 1'b0, 1'b0, 32'h0, "R9 isp erase at L3");
        issue(1'b0, 2'd0, 1'b0, 1'b1, 1'b0, 32'h0, "R9 mbx erase at L3");
        issue(1'b1, 2'd1, 1'b0, 1'b0, 1'b0, 32'h0, "R9 write at L3");
        drain("R4 block");
        do_reset(32'h1234_5678, "R4 unknown");
        issue(1'b0, 2'd0, 1'b1, 1'b0, 1'b0, 32'h0, "R9 isp erase at unknown word");
        drain("R9 block");
        do_reset(32'hFFFF_FFFE, "R4 near-erased");

        // R12 idle: no pulse without requests
        repeat (4) @(negedge clk);
        chk("R12 idle no pulse", {30'd0, req_ack, req_err}, 32'd0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule